// File: doc/BRIEF.md
# SPI Flash Erase Command Front-End

This block is the slave side of a serial NOR flash behavioural model. It listens on an SPI link in mode 0: chip select is active low, MOSI is sampled on the rising serial clock, and MISO changes on the falling serial clock. All SPI inputs are sampled and edge-detected in the system clock domain. Each chip-select frame carries one opcode byte, which may be followed by address bytes. The block keeps a small status register with two flags: a write-enable latch and a write-in-progress flag.

The block decodes the following commands:
- write enable;
- status read;
- three erase sizes: the whole chip, a 64 KB block, or a 4 KB sector.

An erase is accepted only when all of these hold: the write-enable latch is set, no erase is running, and the frame ended after exactly the right number of bytes. An accepted erase starts a busy timer. Each erase size has its own cycle-count parameter. When the timer expires, the block clears both flags and gives a one-cycle completion pulse. The pulse carries the first and last address of the erased range. The memory array itself is not modelled. A host can poll the status register over SPI while an erase is running.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset the status byte reads 0x00, `erase_done` is low and `spi_miso` is low.
- R2: Opcode 0x05 (status read) shifts out 0x00 during the opcode byte. Every later byte of the same frame carries the live status: bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 are zero. Each byte goes out MSB first.
- R3: A frame that holds only opcode 0x06 sets the write-enable latch, so the status then reads 0x02.
- R4: An erase opcode (0xC7, 0xD8 or 0x21) received while the write-enable latch is clear has no effect: no completion pulse follows, and the status stays 0x00.
- R5: A chip erase (0xC7) takes effect only in a one-byte frame. A block erase (0xD8) or sector erase (0x21) takes effect only in a frame of exactly 1 + ADDR_BYTES bytes. A frame with any other length is discarded, and the write-enable latch is left unchanged.
- R6: Take the first rising system-clock edge at which chip select is high after an accepted erase frame as edge 0. Then `erase_done` is high during the cycle that follows edge N+2, where N is CHIP_CYCLES, BLOCK_CYCLES or SECTOR_CYCLES for the erase that was accepted.
- R7: While an accepted erase runs, the status reads 0x03. When it completes, the status returns to 0x00.
- R8: The address is taken MSB first. A block erase reports a range aligned down to 64 KB (low 16 bits zero in the first address, all ones in the last address). A sector erase reports a range aligned down to 4 KB. A chip erase reports 0 to 2^CHIP_LOG2 - 1.
- R9: While an erase runs, every command except the status read is ignored. In particular, a further erase frame produces no second completion pulse.
- R10: `erase_done` is high for exactly one system-clock cycle per accepted erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| erase_done | output | 1 | One-cycle pulse when an erase completes |
| erase_base | output | 8*ADDR_BYTES | First address of the erased range, valid with `erase_done` |
| erase_last | output | 8*ADDR_BYTES | Last address of the erased range, valid with `erase_done` |

## Verification
Every SPI input passes through a two-stage synchronizer and an edge detector before it is used. As a result:
- A received byte acts on the design about three system cycles after its serial clock edge.
- A completion pulse appears N+3 negative clock edges after the bench raises chip select, where N is the timer length.

The bench holds each serial clock phase for eight system cycles, so every MISO bit has settled well before the bench samples it, just ahead of the rising serial edge. For the timing checks the bench counts negative edges from the moment it raises chip select and compares the count with N+3. The absence checks wait more than a sector timer length and then read the status back over SPI.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_CHIP   = 8'hC7;
    localparam logic [7:0] OP_BLOCK  = 8'hD8;
    localparam logic [7:0] OP_SECTOR = 8'h21;

    typedef enum logic [1:0] {
        ER_NONE,
        ER_CHIP,
        ER_BLOCK,
        ER_SECTOR
    } erase_kind_e;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       wel;
        logic       wip;
    } status_t;

    function automatic logic [7:0] status_byte(input logic wel, input logic wip);
        status_t s;
        s.rsvd = '0;
        s.wel  = wel;
        s.wip  = wip;
        return s;
    endfunction

endpackage

// File: rtl/fcf_spi_link.sv
module fcf_spi_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       csn,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       frame_start,
    output logic       frame_end,
    output logic       byte_fin,
    output logic [7:0] rx_next
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] csn_q, sck_q, mosi_q;
    logic [2:0]       bit_cnt;
    logic [7:0]       rx_sr, tx_sr;
    logic             load_pend;
    logic             csn_s, sck_rise, sck_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q  <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
        end else begin
            csn_q  <= {csn_q[DEPTH-2:0], csn};
            sck_q  <= {sck_q[DEPTH-2:0], sck};
            mosi_q <= {mosi_q[DEPTH-2:0], mosi};
        end
    end

    assign csn_s       = csn_q[DEPTH-2];
    assign frame_start = !csn_s && csn_q[DEPTH-1];
    assign frame_end   = csn_s && !csn_q[DEPTH-1];
    assign sck_rise    = sck_q[DEPTH-2] && !sck_q[DEPTH-1];
    assign sck_fall    = !sck_q[DEPTH-2] && sck_q[DEPTH-1];
    assign rx_next     = {rx_sr[6:0], mosi_q[DEPTH-2]};
    assign byte_fin    = !csn_s && !frame_start && sck_rise && (bit_cnt == 3'd7);
    assign miso        = tx_sr[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            load_pend <= 1'b0;
        end else begin
            load_pend <= byte_fin;
            if (frame_start) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else if (!csn_s) begin
                if (sck_rise) begin
                    rx_sr   <= rx_next;
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (load_pend) begin
                    tx_sr <= tx_byte;
                end else if (sck_fall && bit_cnt != 3'd0) begin
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/fcf_cmd_capture.sv
module fcf_cmd_capture #(
    parameter int ADDR_BYTES = 4,
    parameter int CNT_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_start,
    input  logic                    byte_fin,
    input  logic [7:0]              rx_next,
    output logic [7:0]              opcode,
    output logic [CNT_W-1:0]        nbytes,
    output logic [8*ADDR_BYTES-1:0] addr
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ADDR_BYTES + 2);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode <= '0;
            nbytes <= '0;
            addr   <= '0;
        end else if (frame_start) begin
            opcode <= '0;
            nbytes <= '0;
        end else if (byte_fin) begin
            if (nbytes == '0)
                opcode <= rx_next;
            else if (nbytes <= ADDR_END)
                addr <= {addr[ADDR_W-9:0], rx_next};
            if (nbytes != CNT_MAX)
                nbytes <= nbytes + 1'b1;
        end
    end
endmodule

// File: rtl/fcf_cmd_decode.sv
module fcf_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int CNT_W      = 3,
    parameter int CHIP_LOG2  = 23
) (
    input  logic                    frame_end,
    input  logic [7:0]              opcode,
    input  logic [CNT_W-1:0]        nbytes,
    input  logic [8*ADDR_BYTES-1:0] addr,
    input  logic                    wel,
    input  logic                    wip,
    output logic                    set_wel,
    output logic                    start,
    output erase_kind_e             kind,
    output logic [8*ADDR_BYTES-1:0] base,
    output logic [8*ADDR_BYTES-1:0] last
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam logic [ADDR_W-1:0] BLK_LOW  = (ADDR_W'(1) << 16) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SEC_LOW  = (ADDR_W'(1) << 12) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] CHIP_TOP = (ADDR_W'(1) << CHIP_LOG2) - ADDR_W'(1);
    localparam logic [CNT_W-1:0]  LEN_ADDR = CNT_W'(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0]  LEN_ONE  = CNT_W'(1);

    always_comb begin
        set_wel = 1'b0;
        start   = 1'b0;
        kind    = ER_NONE;
        base    = '0;
        last    = '0;
        if (frame_end && !wip) begin
            unique case (opcode)
                OP_WREN: set_wel = (nbytes == LEN_ONE);
                OP_CHIP: if (wel && nbytes == LEN_ONE) begin
                    start = 1'b1;
                    kind  = ER_CHIP;
                    last  = CHIP_TOP;
                end
                OP_BLOCK: if (wel && nbytes == LEN_ADDR) begin
                    start = 1'b1;
                    kind  = ER_BLOCK;
                    base  = addr & ~BLK_LOW;
                    last  = addr | BLK_LOW;
                end
                OP_SECTOR: if (wel && nbytes == LEN_ADDR) begin
                    start = 1'b1;
                    kind  = ER_SECTOR;
                    base  = addr & ~SEC_LOW;
                    last  = addr | SEC_LOW;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fcf_erase_timer.sv
module fcf_erase_timer
    import flash_cmd_pkg::*;
#(
    parameter int TIMER_W       = 32,
    parameter int CHIP_CYCLES   = 1_500_000_000,
    parameter int BLOCK_CYCLES  = 45_000_000,
    parameter int SECTOR_CYCLES = 4_500_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  erase_kind_e kind,
    output logic        fin
);
    logic [TIMER_W-1:0] cnt;
    logic               running;
    logic [TIMER_W-1:0] load_val;

    always_comb begin
        unique case (kind)
            ER_CHIP:   load_val = TIMER_W'(CHIP_CYCLES - 1);
            ER_BLOCK:  load_val = TIMER_W'(BLOCK_CYCLES - 1);
            ER_SECTOR: load_val = TIMER_W'(SECTOR_CYCLES - 1);
            default:   load_val = '0;
        endcase
    end

    assign fin = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start && !running) begin
            cnt     <= load_val;
            running <= 1'b1;
        end else if (fin) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_BYTES    = 4,
    parameter int CHIP_LOG2     = 23,
    parameter int TIMER_W       = 32,
    parameter int CHIP_CYCLES   = 1_500_000_000,
    parameter int BLOCK_CYCLES  = 45_000_000,
    parameter int SECTOR_CYCLES = 4_500_000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_csn,
    input  logic                    spi_sck,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    erase_done,
    output logic [8*ADDR_BYTES-1:0] erase_base,
    output logic [8*ADDR_BYTES-1:0] erase_last
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 3);

    logic              frame_start, frame_end, byte_fin;
    logic [7:0]        rx_next, opcode, tx_byte;
    logic [CNT_W-1:0]  nbytes;
    logic [ADDR_W-1:0] addr, dec_base, dec_last;
    logic              set_wel, start, fin;
    erase_kind_e       kind;
    logic              wel_q, wip_q;

    fcf_spi_link u_link (
        .clk(clk), .rst(rst), .csn(spi_csn), .sck(spi_sck), .mosi(spi_mosi),
        .tx_byte(tx_byte), .miso(spi_miso), .frame_start(frame_start),
        .frame_end(frame_end), .byte_fin(byte_fin), .rx_next(rx_next)
    );

    fcf_cmd_capture #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_fin(byte_fin),
        .rx_next(rx_next), .opcode(opcode), .nbytes(nbytes), .addr(addr)
    );

    fcf_cmd_decode #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .CHIP_LOG2(CHIP_LOG2)) u_dec (
        .frame_end(frame_end), .opcode(opcode), .nbytes(nbytes), .addr(addr),
        .wel(wel_q), .wip(wip_q), .set_wel(set_wel), .start(start), .kind(kind),
        .base(dec_base), .last(dec_last)
    );

    fcf_erase_timer #(
        .TIMER_W(TIMER_W), .CHIP_CYCLES(CHIP_CYCLES),
        .BLOCK_CYCLES(BLOCK_CYCLES), .SECTOR_CYCLES(SECTOR_CYCLES)
    ) u_tmr (
        .clk(clk), .rst(rst), .start(start), .kind(kind), .fin(fin)
    );

    assign tx_byte = (nbytes != '0 && opcode == OP_RDSR) ? status_byte(wel_q, wip_q) : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q      <= 1'b0;
            wip_q      <= 1'b0;
            erase_done <= 1'b0;
            erase_base <= '0;
            erase_last <= '0;
        end else begin
            erase_done <= fin;
            if (fin) begin
                wel_q <= 1'b0;
                wip_q <= 1'b0;
            end else if (start) begin
                wip_q      <= 1'b1;
                erase_base <= dec_base;
                erase_last <= dec_last;
            end else if (set_wel) begin
                wel_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              erase_done,
    input logic [ADDR_W-1:0] erase_base,
    input logic [ADDR_W-1:0] erase_last,
    input logic              wip,
    input logic              wel,
    input logic              start,
    input logic              fin
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        erase_done |=> !erase_done);

    p_start_needs_wel_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> wel);

    p_no_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        wip |-> !start);

    p_busy_has_wel_r7: assert property (@(posedge clk) disable iff (rst)
        wip |-> wel);

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (wip && !fin) |=> wip);

    p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
        erase_done |-> (!wip && !wel));

    p_fin_when_busy_r6: assert property (@(posedge clk) disable iff (rst)
        fin |-> wip);

    p_range_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        erase_done |-> (erase_base[11:0] == 12'h000 && erase_last[11:0] == 12'hFFF
                        && erase_last > erase_base));
endmodule

bind flash_cmd_frontend flash_cmd_checker #(.ADDR_W(8 * ADDR_BYTES)) u_chk (
    .clk(clk), .rst(rst), .erase_done(erase_done), .erase_base(erase_base),
    .erase_last(erase_last), .wip(wip_q), .wel(wel_q), .start(start), .fin(fin)
);

// File: tb/sim_flash_cmd_frontend.sv
module sim_flash_cmd_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int N_CHIP     = 2000;
    localparam int N_BLOCK    = 1200;
    localparam int N_SECTOR   = 700;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csn = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        miso, erase_done;
    logic [31:0] erase_base, erase_last;

    int tests = 0, fails = 0, done_cnt = 0;
    logic [31:0] seen_base, seen_last;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_cmd_frontend #(
        .CHIP_CYCLES(N_CHIP), .BLOCK_CYCLES(N_BLOCK), .SECTOR_CYCLES(N_SECTOR)
    ) u0 (
        .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .erase_done(erase_done), .erase_base(erase_base),
        .erase_last(erase_last)
    );

    always @(negedge clk) begin
        if (erase_done) begin
            done_cnt  <= done_cnt + 1;
            seen_base <= erase_base;
            seen_last <= erase_last;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk);
        csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic xfer(input logic [7:0] out_b, output logic [7:0] in_b);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk);
            mosi = out_b[b];
            wait_clk(HALF - 1);
            in_b[b] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b0, input logic [31:0] a, input int n);
        logic [7:0] d;
        cs_low();
        xfer(b0, d);
        for (int i = 1; i < n; i++) xfer(a[31-8*(i-1) -: 8], d);
        wait_clk(HALF);
        csn = 1'b1;
    endtask

    task automatic read_status(output logic [7:0] first, output logic [7:0] st);
        logic [7:0] again;
        cs_low();
        xfer(8'h05, first);
        xfer(8'h00, st);
        xfer(8'h00, again);
        cs_high();
        if (again !== st) begin
            tests++;
            fails++;
            $display("FAIL R2 repeated status actual=%0h expected=%0h", again, st);
        end
    endtask

    task automatic expect_status(input string tag, input logic [7:0] exp);
        logic [7:0] f, s;
        read_status(f, s);
        check({tag, " status"}, s, exp);
        check("R2 opcode-phase byte", f, 8'h00);
    endtask

    task automatic wren();
        send(8'h06, 32'h0, 1);
        wait_clk(HALF);
    endtask

    task automatic measure_done(input string tag, input int n);
        int k;
        k = 0;
        while (k < n + 50 && !erase_done) begin
            @(negedge clk);
            k++;
        end
        check(tag, k, n + 3);
        wait_clk(4);
    endtask

    task automatic t_reset();
        wait_clk(2);
        check("R1 miso after reset", miso, 1'b0);
        check("R1 erase_done after reset", erase_done, 1'b0);
        expect_status("R1", 8'h00);
    endtask

    task automatic t_no_wel();
        int c0;
        c0 = done_cnt;
        send(8'h21, 32'h0000_1000, 5);
        send(8'hC7, 32'h0, 1);
        wait_clk(N_SECTOR + 100);
        check("R4 no done without latch", done_cnt, c0);
        expect_status("R4", 8'h00);
    endtask

    task automatic t_wren();
        wren();
        expect_status("R3", 8'h02);
    endtask

    task automatic t_length();
        int c0;
        c0 = done_cnt;
        send(8'hD8, 32'h0001_0000, 4);
        send(8'hC7, 32'hFF00_0000, 2);
        send(8'h21, 32'h0000_2000, 6);
        wait_clk(N_SECTOR + 100);
        check("R5 wrong length discarded", done_cnt, c0);
        expect_status("R5 latch kept", 8'h02);
    endtask

    task automatic t_sector();
        int c0;
        c0 = done_cnt;
        send(8'h21, 32'h0000_ABCD, 5);
        measure_done("R6 sector timing", N_SECTOR);
        check("R10 one pulse sector", done_cnt, c0 + 1);
        check("R8 sector base", seen_base, 32'h0000_A000);
        check("R8 sector last", seen_last, 32'h0000_AFFF);
        expect_status("R7 after sector", 8'h00);
    endtask

    task automatic t_block();
        int c0;
        wren();
        c0 = done_cnt;
        send(8'hD8, 32'h1234_5678, 5);
        measure_done("R6 block timing", N_BLOCK);
        check("R10 one pulse block", done_cnt, c0 + 1);
        check("R8 block base", seen_base, 32'h1234_0000);
        check("R8 block last", seen_last, 32'h1234_FFFF);
    endtask

    task automatic t_chip();
        int c0;
        wren();
        c0 = done_cnt;
        send(8'hC7, 32'h0, 1);
        measure_done("R6 chip timing", N_CHIP);
        check("R8 chip base", seen_base, 32'h0);
        check("R8 chip last", seen_last, 32'h007F_FFFF);
        check("R10 one pulse chip", done_cnt, c0 + 1);
    endtask

    task automatic t_busy();
        int c0;
        wren();
        c0 = done_cnt;
        send(8'hC7, 32'h0, 1);
        wait_clk(HALF);
        expect_status("R7 during erase", 8'h03);
        send(8'h21, 32'h0000_3000, 5);
        wait_clk(N_CHIP + N_SECTOR + 100);
        check("R9 single done while busy", done_cnt, c0 + 1);
        check("R9 range of first erase", seen_last, 32'h007F_FFFF);
        expect_status("R7 after chip erase", 8'h00);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        t_reset();
        t_no_wel();
        t_wren();
        t_length();
        t_sector();
        t_block();
        t_chip();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end
endmodule